// File: doc/BRIEF.md
# DDR SDRAM Refresh Scheduler

This block keeps a DDR SDRAM refreshed on behalf of a memory controller. A free-running interval timer produces one tick per average refresh interval (the row-retention window divided by the row count; with 4096 rows and a 32 ms window that is about 7.8 µs). Each tick adds one unit of refresh debt. Each auto-refresh command the block issues removes one. While debt is outstanding the block raises a request to the controller's arbiter. It escalates that request to urgent once debt reaches its ceiling of eight. From then on the arbiter has to grant before the next interval expires, so that no two refreshes are ever more than nine intervals apart.

On a grant the block takes the command bus. If the controller reports any bank as open, the block first issues a precharge-all and waits out the precharge time. It then issues the refresh command and holds the bus with NOP commands for the refresh cycle time. If the grant is still held and debt remains, it issues further refreshes back to back. No more than eight are issued in one tenure, after which the bus is handed back for at least one cycle. While the block does not own the bus it drives a deselect, so that an external multiplexer can merge its pins with the controller's own.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset the block drives deselect (chip select high, all other command pins high, A10 low), and busy, request and urgent are all low.
- R2: The interval timer ticks every `cfg_trefi` cycles, counted from reset release. The request output first rises on cycle `cfg_trefi`, and debt grows by one per tick. A `cfg_trefi` of zero selects the parameter default.
- R3: Urgent is high exactly while debt equals eight. Debt saturates at eight, so ticks that arrive at the ceiling are not accumulated.
- R4: If any bit of `banks_open` is set when a grant is taken, the next cycle carries precharge-all (chip select low, row strobe low, column strobe high, write enable low, A10 high). The refresh follows exactly `cfg_trp` cycles later, with `cfg_trp` treated as at least 2.
- R5: If no bank is open when a grant is taken, the refresh is driven on the cycle after the grant is sampled.
- R6: A refresh is encoded as chip select, row strobe and column strobe low with write enable high and A10 low. Each refresh removes one unit of debt, and request falls once debt reaches zero.
- R7: Each refresh is followed by NOPs until `cfg_trfc` cycles have passed (`cfg_trfc` treated as at least 2). Only then is another refresh issued or the bus released.
- R8: While the grant stays high and debt remains, refreshes continue back to back at `cfg_trfc` spacing. After the eighth refresh of one tenure the block releases the bus for at least one cycle before it can take it again.
- R9: Busy is high exactly while the block owns the bus. Chip select is high whenever busy is low. Every owned cycle that carries neither precharge-all nor refresh carries a NOP (chip select low, the three strobes high).
- R10: A grant that arrives while no debt is outstanding is ignored: no command is driven and busy stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_trefi | input | TREFI_W | Average refresh interval in cycles (0 selects the default) |
| cfg_trp | input | TIMING_W | Precharge time in cycles |
| cfg_trfc | input | TIMING_W | Refresh cycle time in cycles |
| banks_open | input | NUM_BANKS | One bit per bank, set while that bank has an open row |
| ref_req | output | 1 | Debt outstanding and bus not owned |
| ref_urgent | output | 1 | Debt at its ceiling; grant needed within the current interval |
| ref_grant | input | 1 | Arbiter grant, level sensitive |
| ref_busy | output | 1 | Block owns the command bus |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_a10 | output | 1 | Address bit 10 (all-bank select for precharge) |

## Verification
The hardest condition to reach is the burst limit with debt still left over at the end. Eight refreshes in one tenure drain eight units of debt, so the limit only matters if a tick lands inside the burst. The stimulus lets debt climb to its ceiling and then holds the grant through the whole burst, which makes a tick fall before the eighth refresh. It then checks that the bus is released and that a fresh request follows at once. Saturation gets a second run to the ceiling, held one interval past it. The interval is then stretched so that no new tick can come in. If saturation were missing, a ninth unit would survive the burst, and the bench looks for that unit as a request still standing after release.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

   typedef enum logic [1:0] {
      CMD_DESEL = 2'd0,
      CMD_NOP   = 2'd1,
      CMD_PREA  = 2'd2,
      CMD_REF   = 2'd3
   } ref_cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_PREA     = 3'd1,
      ST_WAIT_RP  = 3'd2,
      ST_REF      = 3'd3,
      ST_WAIT_RFC = 3'd4
   } seq_state_e;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
      logic a10;
   } cmd_pins_t;

   localparam cmd_pins_t PINS_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};

   function automatic cmd_pins_t encode_cmd(input ref_cmd_e c);
      cmd_pins_t p;
      case (c)
         CMD_NOP:  p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
         CMD_PREA: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1};
         CMD_REF:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};
         default:  p = PINS_DESEL;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/refi_timer.sv
module refi_timer #(
   parameter int TREFI_W       = 16,
   parameter int DEFAULT_TREFI = 780,
   parameter bit ZERO_DEFAULT  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TREFI_W-1:0] cfg_trefi,
   output logic               tick_o
);

   logic [TREFI_W-1:0] period;
   logic [TREFI_W-1:0] cnt_q;

   generate
      if (ZERO_DEFAULT) begin : g_zero_default
         assign period = (cfg_trefi == '0) ? TREFI_W'(DEFAULT_TREFI) : cfg_trefi;
      end else begin : g_zero_one
         assign period = (cfg_trefi == '0) ? TREFI_W'(1) : cfg_trefi;
      end
   endgenerate

   assign tick_o = (cnt_q >= period - TREFI_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + TREFI_W'(1);
   end

   // R2: with a period above one cycle, ticks never come back to back
   assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && period > TREFI_W'(1) && $stable(period)) |=> !tick_o);

endmodule

// File: rtl/refresh_debt.sv
module refresh_debt #(
   parameter int MAX_DEBT = 8,
   localparam int DEBT_W  = $clog2(MAX_DEBT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic ref_i,
   output logic pending_o,
   output logic urgent_o
);

   logic [DEBT_W-1:0] debt_q;
   logic [DEBT_W-1:0] debt_d;
   logic              at_max;

   assign at_max = (debt_q == DEBT_W'(MAX_DEBT));

   always_comb begin
      debt_d = debt_q;
      unique case ({tick_i, ref_i})
         2'b10:   if (!at_max) debt_d = debt_q + DEBT_W'(1);
         2'b01:   if (debt_q != '0) debt_d = debt_q - DEBT_W'(1);
         default: debt_d = debt_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) debt_q <= '0;
      else        debt_q <= debt_d;
   end

   assign pending_o = (debt_q != '0);
   assign urgent_o  = at_max;

   // R3: debt never climbs past its ceiling
   assert_debt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      debt_q <= DEBT_W'(MAX_DEBT));

   // R6: the sequencer only refreshes against outstanding debt
   assert_ref_has_debt_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ref_i |-> (debt_q != '0));

   // R3: a tick at the ceiling without a refresh leaves debt at the ceiling
   assert_saturate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (at_max && tick_i && !ref_i) |=> urgent_o);

endmodule

// File: rtl/refresh_seq.sv
module refresh_seq
   import dram_refresh_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int TIMING_W  = 8,
   parameter int MAX_BURST = 8,
   localparam int BURST_W  = $clog2(MAX_BURST + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pending_i,
   input  logic                 grant_i,
   input  logic [NUM_BANKS-1:0] banks_open_i,
   input  logic [TIMING_W-1:0]  cfg_trp,
   input  logic [TIMING_W-1:0]  cfg_trfc,
   output logic                 req_o,
   output logic                 busy_o,
   output logic                 ref_issue_o,
   output ref_cmd_e             cmd_o
);

   seq_state_e          state_q, state_d;
   logic [TIMING_W-1:0] wait_q, wait_d;
   logic [BURST_W-1:0]  burst_q, burst_d;
   logic [TIMING_W-1:0] trp_eff, trfc_eff;
   logic                keep_bus;

   assign trp_eff  = (cfg_trp  < TIMING_W'(2)) ? TIMING_W'(2) : cfg_trp;
   assign trfc_eff = (cfg_trfc < TIMING_W'(2)) ? TIMING_W'(2) : cfg_trfc;
   assign keep_bus = grant_i && pending_i && (burst_q < BURST_W'(MAX_BURST));

   always_comb begin
      state_d = state_q;
      wait_d  = wait_q;
      burst_d = burst_q;
      unique case (state_q)
         ST_IDLE: begin
            if (pending_i && grant_i) begin
               burst_d = '0;
               state_d = (|banks_open_i) ? ST_PREA : ST_REF;
            end
         end
         ST_PREA: begin
            wait_d  = trp_eff - TIMING_W'(2);
            state_d = ST_WAIT_RP;
         end
         ST_WAIT_RP: begin
            if (wait_q == '0) state_d = ST_REF;
            else              wait_d  = wait_q - TIMING_W'(1);
         end
         ST_REF: begin
            burst_d = burst_q + BURST_W'(1);
            wait_d  = trfc_eff - TIMING_W'(2);
            state_d = ST_WAIT_RFC;
         end
         ST_WAIT_RFC: begin
            if (wait_q == '0) state_d = keep_bus ? ST_REF : ST_IDLE;
            else              wait_d  = wait_q - TIMING_W'(1);
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         wait_q  <= '0;
         burst_q <= '0;
      end else begin
         state_q <= state_d;
         wait_q  <= wait_d;
         burst_q <= burst_d;
      end
   end

   always_comb begin
      unique case (state_q)
         ST_IDLE:               cmd_o = CMD_DESEL;
         ST_PREA:               cmd_o = CMD_PREA;
         ST_REF:                cmd_o = CMD_REF;
         ST_WAIT_RP, ST_WAIT_RFC: cmd_o = CMD_NOP;
         default:               cmd_o = CMD_DESEL;
      endcase
   end

   assign busy_o      = (state_q != ST_IDLE);
   assign req_o       = pending_i && (state_q == ST_IDLE);
   assign ref_issue_o = (state_q == ST_REF);

   // cycles elapsed since the last precharge-all, saturating
   logic [TIMING_W-1:0] rp_age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     rp_age_q <= '1;
      else if (state_q == ST_PREA)    rp_age_q <= TIMING_W'(1);
      else if (rp_age_q != '1)        rp_age_q <= rp_age_q + TIMING_W'(1);
   end

   // R4: a refresh that follows a precharge wait honours the precharge time
   assert_rp_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_REF && $past(state_q) == ST_WAIT_RP) |-> (rp_age_q >= trp_eff));

   // R8: one tenure never holds more refreshes than the burst limit
   assert_burst_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      burst_q <= BURST_W'(MAX_BURST));

   // R10: without debt the sequencer stays off the bus
   assert_grant_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && !pending_i) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/refresh_cmd_out.sv
module refresh_cmd_out
   import dram_refresh_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  ref_cmd_e  cmd_i,
   input  logic      busy_i,
   output cmd_pins_t pins_o,
   output logic      busy_o
);

   generate
      if (OUT_REG) begin : g_registered
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pins_o <= PINS_DESEL;
               busy_o <= 1'b0;
            end else begin
               pins_o <= encode_cmd(cmd_i);
               busy_o <= busy_i;
            end
         end
      end else begin : g_direct
         assign pins_o = encode_cmd(cmd_i);
         assign busy_o = busy_i;
      end
   endgenerate

   // R9: the pins are deselected whenever the block does not own the bus
   assert_desel_when_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> pins_o.cs_n);

   // R9: an owned bus always carries a selected command
   assert_selected_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !pins_o.cs_n);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
   import dram_refresh_pkg::*;
#(
   parameter int NUM_BANKS     = 4,
   parameter int TREFI_W       = 16,
   parameter int TIMING_W      = 8,
   parameter int DEFAULT_TREFI = 780,
   parameter bit ZERO_DEFAULT  = 1'b1,
   parameter int MAX_DEBT      = 8,
   parameter int MAX_BURST     = 8,
   parameter bit OUT_REG       = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [TREFI_W-1:0]   cfg_trefi,
   input  logic [TIMING_W-1:0]  cfg_trp,
   input  logic [TIMING_W-1:0]  cfg_trfc,
   input  logic [NUM_BANKS-1:0] banks_open,
   output logic                 ref_req,
   output logic                 ref_urgent,
   input  logic                 ref_grant,
   output logic                 ref_busy,
   output logic                 cmd_cs_n,
   output logic                 cmd_ras_n,
   output logic                 cmd_cas_n,
   output logic                 cmd_we_n,
   output logic                 cmd_a10
);

   generate
      if (NUM_BANKS < 1)     begin : g_bad_banks $error("NUM_BANKS must be at least 1"); end
      if (TIMING_W < 2)      begin : g_bad_tw    $error("TIMING_W must be at least 2"); end
      if (MAX_DEBT < 1)      begin : g_bad_debt  $error("MAX_DEBT must be at least 1"); end
      if (MAX_BURST < 1)     begin : g_bad_burst $error("MAX_BURST must be at least 1"); end
      if (DEFAULT_TREFI < 2 || DEFAULT_TREFI >= (1 << TREFI_W))
                             begin : g_bad_refi  $error("DEFAULT_TREFI out of range"); end
   endgenerate

   logic      tick;
   logic      pending;
   logic      ref_issue;
   logic      seq_busy;
   ref_cmd_e  seq_cmd;
   cmd_pins_t pins;

   refi_timer #(
      .TREFI_W      (TREFI_W),
      .DEFAULT_TREFI(DEFAULT_TREFI),
      .ZERO_DEFAULT (ZERO_DEFAULT)
   ) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_trefi(cfg_trefi),
      .tick_o   (tick)
   );

   refresh_debt #(
      .MAX_DEBT(MAX_DEBT)
   ) debt_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick),
      .ref_i    (ref_issue),
      .pending_o(pending),
      .urgent_o (ref_urgent)
   );

   refresh_seq #(
      .NUM_BANKS(NUM_BANKS),
      .TIMING_W (TIMING_W),
      .MAX_BURST(MAX_BURST)
   ) seq_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .pending_i   (pending),
      .grant_i     (ref_grant),
      .banks_open_i(banks_open),
      .cfg_trp     (cfg_trp),
      .cfg_trfc    (cfg_trfc),
      .req_o       (ref_req),
      .busy_o      (seq_busy),
      .ref_issue_o (ref_issue),
      .cmd_o       (seq_cmd)
   );

   refresh_cmd_out #(
      .OUT_REG(OUT_REG)
   ) out_i (
      .clk   (clk),
      .rst_n (rst_n),
      .cmd_i (seq_cmd),
      .busy_i(seq_busy),
      .pins_o(pins),
      .busy_o(ref_busy)
   );

   assign cmd_cs_n  = pins.cs_n;
   assign cmd_ras_n = pins.ras_n;
   assign cmd_cas_n = pins.cas_n;
   assign cmd_we_n  = pins.we_n;
   assign cmd_a10   = pins.a10;

   // pin-level refresh spacing monitor
   logic                ref_on_pins;
   logic                ref_seen_q;
   logic [TIMING_W-1:0] since_ref_q;

   assign ref_on_pins = !cmd_cs_n && !cmd_ras_n && !cmd_cas_n && cmd_we_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_seen_q  <= 1'b0;
         since_ref_q <= '0;
      end else if (ref_on_pins) begin
         ref_seen_q  <= 1'b1;
         since_ref_q <= TIMING_W'(1);
      end else if (since_ref_q != '1) begin
         since_ref_q <= since_ref_q + TIMING_W'(1);
      end
   end

   // R7: refreshes on the pins are at least the refresh cycle time apart
   assert_rfc_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_on_pins && ref_seen_q) |-> (since_ref_q >= cfg_trfc));

   // R3: urgency never appears without outstanding debt
   assert_urgent_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ref_urgent |-> (ref_req || ref_busy));

endmodule

// File: tb/dram_refresh_sched_tb_top.sv
module dram_refresh_sched_tb_top;

   localparam int T_REFI = 40;
   localparam int T_RP   = 3;
   localparam int T_RFC  = 6;
   localparam int K_PRE  = 1;
   localparam int K_REF  = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cfg_trefi = 16'(T_REFI);
   logic [7:0]  cfg_trp = 8'(T_RP);
   logic [7:0]  cfg_trfc = 8'(T_RFC);
   logic [3:0]  banks_open = 4'b0000;
   logic        ref_grant = 1'b0;
   logic        ref_req, ref_urgent, ref_busy;
   logic        cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_a10;

   always #5 clk = ~clk;

   dram_refresh_sched dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_trefi (cfg_trefi),
      .cfg_trp   (cfg_trp),
      .cfg_trfc  (cfg_trfc),
      .banks_open(banks_open),
      .ref_req   (ref_req),
      .ref_urgent(ref_urgent),
      .ref_grant (ref_grant),
      .ref_busy  (ref_busy),
      .cmd_cs_n  (cmd_cs_n),
      .cmd_ras_n (cmd_ras_n),
      .cmd_cas_n (cmd_cas_n),
      .cmd_we_n  (cmd_we_n),
      .cmd_a10   (cmd_a10)
   );

   int cyc = 0;
   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   typedef struct {
      int    at;
      int    kind;
      string req;
   } exp_t;
   exp_t exp_q[$];

   task automatic push_exp(input int at, input int kind, input string req);
      exp_t e;
      e.at = at; e.kind = kind; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic wait_cyc(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   // monitor: decodes the pins and compares against the scoreboard
   int last_ref = -1;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int kind;
         kind = 0;
         if (!cmd_cs_n && !cmd_ras_n && cmd_cas_n && !cmd_we_n && cmd_a10) kind = K_PRE;
         if (!cmd_cs_n && !cmd_ras_n && !cmd_cas_n && cmd_we_n && !cmd_a10) kind = K_REF;
         // R9: free bus is deselected, owned bus is either a command or a NOP
         if (!ref_busy && !cmd_cs_n)
            chk(1'b0, "R9", "selected while not busy", cyc, -1);
         if (ref_busy && kind == 0 &&
             !(!cmd_cs_n && cmd_ras_n && cmd_cas_n && cmd_we_n))
            chk(1'b0, "R9", "owned cycle not a NOP", cyc, -1);
         if (kind != 0) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R4", "unexpected command kind", kind, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(e.kind == kind, e.req, "command kind", kind, e.kind);
               chk(e.at == cyc, e.req, "command cycle", cyc, e.at);
            end
            if (kind == K_PRE) banks_open = 4'b0000;
            if (kind == K_REF) begin
               if (last_ref >= 0)
                  chk(cyc - last_ref <= 9 * T_REFI, "R2", "refresh gap",
                      cyc - last_ref, 9 * T_REFI);
               last_ref = cyc;
            end
         end
      end
   end

   task automatic finish_run();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "R1", "watchdog expired", cyc, 0);
      finish_run();
   end

   initial begin
      int k;
      bit bad;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk(cmd_cs_n && cmd_ras_n && cmd_cas_n && cmd_we_n && !cmd_a10, "R1",
          "pins after reset", {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_a10}, 5'b11110);
      chk(!ref_busy && !ref_req && !ref_urgent, "R1", "status after reset",
          {ref_busy, ref_req, ref_urgent}, 0);

      // R2: first request after one interval
      while (!ref_req) @(negedge clk);
      chk(cyc == T_REFI, "R2", "first request cycle", cyc, T_REFI);
      chk(!ref_urgent, "R3", "urgent with one unit of debt", ref_urgent, 0);

      // R4: open bank forces precharge-all then refresh after tRP
      k = cyc;
      banks_open = 4'b0010;
      push_exp(k + 1, K_PRE, "R4");
      push_exp(k + 1 + T_RP, K_REF, "R4");
      ref_grant = 1'b1;
      @(negedge clk);
      ref_grant = 1'b0;
      wait_cyc(k + T_RP + T_RFC);
      chk(ref_busy, "R7", "bus held during refresh cycle", ref_busy, 1);
      @(negedge clk);
      chk(!ref_busy, "R7", "bus released after tRFC", ref_busy, 0);
      chk(!ref_req, "R6", "request cleared after debt paid", ref_req, 0);

      // R10: grant with no debt
      bad = 1'b0;
      ref_grant = 1'b1;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (ref_busy || !cmd_cs_n) bad = 1'b1;
      end
      ref_grant = 1'b0;
      chk(!bad, "R10", "grant without debt caused activity", bad, 0);

      // R5: closed banks, refresh right after grant
      while (!ref_req) @(negedge clk);
      chk(cyc == 2 * T_REFI, "R2", "second request cycle", cyc, 2 * T_REFI);
      k = cyc;
      push_exp(k + 1, K_REF, "R5");
      ref_grant = 1'b1;
      @(negedge clk);
      ref_grant = 1'b0;
      wait_cyc(k + 1 + T_RFC);
      chk(!ref_req && !ref_busy, "R6", "idle after single refresh", {ref_req, ref_busy}, 0);

      // R3: urgent exactly when eight units accumulate
      while (!ref_urgent) @(negedge clk);
      chk(cyc == 10 * T_REFI, "R3", "urgent rise cycle", cyc, 10 * T_REFI);

      // R8: held grant, burst limit with a tick inside the burst
      k = cyc;
      for (int i = 0; i < 8; i++) push_exp(k + 1 + i * T_RFC, K_REF, "R8");
      push_exp(k + 2 + 8 * T_RFC, K_REF, "R8");
      ref_grant = 1'b1;
      wait_cyc(k + 1 + 8 * T_RFC);
      chk(!ref_busy, "R8", "bus released after burst limit", ref_busy, 0);
      chk(ref_req, "R8", "leftover debt requests again", ref_req, 1);
      @(negedge clk);
      ref_grant = 1'b0;
      wait_cyc(k + 2 + 9 * T_RFC);
      chk(!ref_busy && !ref_req, "R6", "debt cleared after extra refresh",
          {ref_busy, ref_req}, 0);

      // R3: saturation - one tick past the ceiling is dropped
      wait_cyc(20 * T_REFI);
      chk(ref_urgent, "R3", "urgent held at ceiling", ref_urgent, 1);
      k = cyc;
      cfg_trefi = 16'd20000;
      for (int i = 0; i < 8; i++) push_exp(k + 1 + i * T_RFC, K_REF, "R3");
      ref_grant = 1'b1;
      wait_cyc(k + 1 + 8 * T_RFC);
      chk(!ref_req && !ref_busy, "R3", "no debt beyond ceiling", {ref_req, ref_busy}, 0);
      ref_grant = 1'b0;
      repeat (4) @(negedge clk);
      chk(!ref_req, "R3", "request stays low", ref_req, 0);
      chk(exp_q.size() == 0, "R4", "scoreboard drained", exp_q.size(), 0);
      finish_run();
   end

endmodule